// File: doc/BRIEF.md
# Multidrop Serial Receiver with Hunt Filter

This block receives asynchronous serial characters, oversampling the line at sixteen samples per bit. Characters have 5 to 8 data bits, sent least significant bit first. In the two multidrop modes an extra address/data bit follows the data bits. Each good character leaves the block as an 8-bit byte, an address flag and a one-cycle valid strobe. A character whose stop bit samples low gives a one-cycle framing-error pulse and is not delivered.

Between the deserializer and the output sits a hunt filter. While the filter is hunting it discards characters. How it stops hunting depends on a 2-bit mode code:
- In normal mode, a full character time of idle line ends the hunt.
- In manual multidrop mode, any character with its address bit set ends the hunt.
- In automatic multidrop mode, an address character ends the hunt only if it equals one of two stored address values.

This lets a node on a shared line ignore traffic that is not meant for it.

Top module: `mdrop_uart_rx`

## Requirements
- R1: In reset and on the first cycle after it, valid_o, frame_err_o, is_addr_o and data_o are 0, and the filter is hunting.
- R2: A frame is one low start bit, then N data bits least significant bit first, where N is 5, 6, 7 or 8 for len_i 00, 01, 10 or 11. In modes 01 and 11 one address/data bit follows the data bits. One stop bit closes the frame. data_o bits at and above N are 0.
- R3: In mode 00 (and in the reserved mode 10), characters are discarded while hunting. The hunt ends once the line has stayed high for (N + 2 + address-bit count) bit times with no start bit. After that, characters are delivered with is_addr_o = 0.
- R4: In mode 01, a character whose address bit is 1 ends the hunt and is delivered with is_addr_o = 1. Characters with address bit 0 are discarded while hunting and are delivered with is_addr_o = 0 otherwise.
- R5: In mode 11, an address character equal to addr0_i or addr1_i ends the hunt and is delivered with is_addr_o = 1. Data characters that follow it are delivered.
- R6: In mode 11, an address character matching neither stored address is discarded and returns the filter to hunting. Later data characters are discarded until a matching address arrives. An idle line does not end the hunt in modes 01 and 11.
- R7: A stop bit sampled low gives a one-cycle frame_err_o pulse. The character is not delivered, and the filter returns to hunting.
- R8: Only one stop bit is checked. A start bit that immediately follows a single stop bit is received.
- R9: A low pulse on rx_i shorter than half a bit time produces no character and no error.
- R10: valid_o and frame_err_o are each high for one cycle only, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| mode_i | input | 2 | 00 normal, 01 manual multidrop, 10 reserved (as 00), 11 automatic multidrop |
| len_i | input | 2 | Data length code: 00=5, 01=6, 10=7, 11=8 bits |
| addr0_i | input | 8 | First stored node address |
| addr1_i | input | 8 | Second stored node address |
| data_o | output | 8 | Received character, zero-extended |
| is_addr_o | output | 1 | Delivered character was an address character |
| valid_o | output | 1 | One-cycle strobe for a delivered character |
| frame_err_o | output | 1 | One-cycle strobe for a low stop bit |

## Verification
A single received frame can both report a framing error and force the filter back into hunting. This collision matters most when the bad frame is an address character in automatic mode, which would otherwise have ended the hunt. The bench sends such frames with the stop bit held low, both in normal mode and in automatic mode. It then judges the result at the ports. The error pulse must appear without a valid strobe, and the data characters that follow must be discarded until an idle period (normal mode) or a matching address (automatic mode) has been seen. An idle period sent in automatic mode right after the error must not end the hunt.

// File: rtl/mdrop_rx_pkg.sv
// Package: shared types and helpers for the multidrop serial receiver.
// Assumes: one character is at most 8 data bits plus one address bit.
package mdrop_rx_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'b00,
        MD_MANUAL = 2'b01,
        MD_RSVD   = 2'b10,
        MD_AUTO   = 2'b11
    } md_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Two-of-three majority vote of line samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_tick_gen.sv
// Oversample tick generator: pulses once every DIV clocks.
// Assumes: DIV >= 1; the tick is one clock wide.
module rx_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Free-running divider producing one tick per DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_deser.sv
// Deserializer: finds start bits, votes each bit on the three samples
// around mid-bit, and assembles data plus an optional address bit.
// It also pulses idle_o after the line has been high for one full
// character time.
// Assumes: rx_s is already synchronized; tick_i marks one oversample.
module rx_deser #(
    parameter int OVS  = 16,
    parameter int MAXB = 8,
    parameter int MINB = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            rx_s,
    input  logic [1:0]      len_i,
    input  logic            abit_en_i,
    output logic            chr_valid_o,
    output logic [MAXB-1:0] chr_data_o,
    output logic            chr_addr_o,
    output logic            chr_ferr_o,
    output logic            idle_o
);
    import mdrop_rx_pkg::*;

    localparam int SW   = $clog2(OVS);
    localparam int MID  = OVS / 2;
    localparam int BW   = $clog2(MAXB + 2);
    localparam int DIW  = $clog2(MAXB);
    localparam int ICW  = $clog2((MAXB + 3) * OVS + 1);

    rx_state_e      st;
    logic [SW-1:0]  scnt;
    logic [BW-1:0]  bidx;
    logic [1:0]     sh;
    logic [ICW-1:0] idle_cnt;
    logic           vote;
    logic [BW-1:0]  nbits;
    logic [BW-1:0]  last_bit;
    logic [ICW-1:0] idle_tgt;

    // Per-character length values and the current bit vote.
    always_comb begin
        nbits    = BW'(MINB) + BW'(len_i);
        last_bit = nbits + BW'(abit_en_i) - 1'b1;
        idle_tgt = ICW'(nbits + BW'(abit_en_i) + BW'(2)) * ICW'(OVS);
        vote     = maj3(sh[1], sh[0], rx_s);
    end

    // Frame state machine, bit capture and idle-line timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= RX_IDLE;
            scnt        <= '0;
            bidx        <= '0;
            sh          <= 2'b11;
            idle_cnt    <= '0;
            chr_valid_o <= 1'b0;
            chr_data_o  <= '0;
            chr_addr_o  <= 1'b0;
            chr_ferr_o  <= 1'b0;
            idle_o      <= 1'b0;
        end else begin
            chr_valid_o <= 1'b0;
            idle_o      <= 1'b0;
            if (tick_i) begin
                sh <= {sh[0], rx_s};
                if (st == RX_IDLE) begin
                    scnt <= '0;
                    if (!rx_s) begin
                        st         <= RX_START;
                        scnt       <= SW'(1);
                        idle_cnt   <= '0;
                        chr_data_o <= '0;
                        chr_addr_o <= 1'b0;
                    end else if (idle_cnt < idle_tgt) begin
                        idle_cnt <= idle_cnt + 1'b1;
                        if (idle_cnt == idle_tgt - 1'b1) idle_o <= 1'b1;
                    end
                end else begin
                    if (scnt == SW'(MID + 1)) begin
                        case (st)
                            RX_START: if (vote) st <= RX_IDLE;
                            RX_DATA: begin
                                if (bidx < nbits) chr_data_o[bidx[DIW-1:0]] <= vote;
                                else              chr_addr_o <= vote;
                            end
                            RX_STOP: begin
                                chr_valid_o <= 1'b1;
                                chr_ferr_o  <= ~vote;
                                st          <= RX_IDLE;
                                idle_cnt    <= '0;
                            end
                            default: ;
                        endcase
                    end
                    if (scnt == SW'(OVS - 1)) begin
                        scnt <= '0;
                        if (st == RX_START) begin
                            st   <= RX_DATA;
                            bidx <= '0;
                        end else if (st == RX_DATA) begin
                            if (bidx == last_bit) st <= RX_STOP;
                            else                  bidx <= bidx + 1'b1;
                        end
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_hunt_filter.sv
// Hunt filter: decides which characters are delivered, according to the
// mode. It compares address characters with NADDR stored addresses.
// Assumes: at most one of chr_valid_i and idle_i is high in a cycle.
module rx_hunt_filter #(
    parameter int W     = 8,
    parameter int NADDR = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic [NADDR-1:0][W-1:0] addr_tab_i,
    input  logic                  chr_valid_i,
    input  logic [W-1:0]          chr_data_i,
    input  logic                  chr_addr_i,
    input  logic                  chr_ferr_i,
    input  logic                  idle_i,
    output logic [W-1:0]          data_o,
    output logic                  is_addr_o,
    output logic                  valid_o,
    output logic                  frame_err_o
);
    import mdrop_rx_pkg::*;

    logic [NADDR-1:0] hit;
    logic             hunting;
    logic             accept;
    logic             flag;
    logic             hunt_nxt;

    // One comparator per stored address.
    for (genvar g = 0; g < NADDR; g++) begin : g_cmp
        assign hit[g] = (chr_data_i == addr_tab_i[g]);
    end

    // Mode-dependent acceptance and next hunt state for a good character.
    always_comb begin
        accept   = 1'b0;
        flag     = 1'b0;
        hunt_nxt = hunting;
        case (md_mode_e'(mode_i))
            MD_MANUAL: begin
                if (chr_addr_i) begin
                    accept = 1'b1; flag = 1'b1; hunt_nxt = 1'b0;
                end else begin
                    accept = ~hunting;
                end
            end
            MD_AUTO: begin
                if (chr_addr_i) begin
                    accept = |hit; flag = |hit; hunt_nxt = ~(|hit);
                end else begin
                    accept = ~hunting;
                end
            end
            default: accept = ~hunting;
        endcase
    end

    // Hunt state register and registered output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunting     <= 1'b1;
            data_o      <= '0;
            is_addr_o   <= 1'b0;
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
            if (idle_i && !mode_i[0]) hunting <= 1'b0;
            if (chr_valid_i) begin
                if (chr_ferr_i) begin
                    frame_err_o <= 1'b1;
                    hunting     <= 1'b1;
                end else begin
                    hunting <= hunt_nxt;
                    if (accept) begin
                        valid_o   <= 1'b1;
                        data_o    <= chr_data_i;
                        is_addr_o <= flag;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdrop_uart_rx.sv
// Top: multidrop serial receiver with hunt filter. It synchronizes the
// line, oversamples it, deserializes characters and filters them.
// Assumes: configuration inputs change only while the line is idle.
module mdrop_uart_rx #(
    parameter int OVS = 16,
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] len_i,
    input  logic [7:0] addr0_i,
    input  logic [7:0] addr1_i,
    output logic [7:0] data_o,
    output logic       is_addr_o,
    output logic       valid_o,
    output logic       frame_err_o
);
    localparam int W     = 8;
    localparam int NADDR = 2;

    logic [1:0]            sync_q;
    logic                  tick;
    logic                  chr_valid;
    logic [W-1:0]          chr_data;
    logic                  chr_addr;
    logic                  chr_ferr;
    logic                  idle;
    logic [NADDR-1:0][W-1:0] addr_tab;

    assign addr_tab[0] = addr0_i;
    assign addr_tab[1] = addr1_i;

    // Two-stage synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    rx_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rx_deser #(.OVS(OVS), .MAXB(W), .MINB(5)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .rx_s        (sync_q[1]),
        .len_i       (len_i),
        .abit_en_i   (mode_i[0]),
        .chr_valid_o (chr_valid),
        .chr_data_o  (chr_data),
        .chr_addr_o  (chr_addr),
        .chr_ferr_o  (chr_ferr),
        .idle_o      (idle)
    );

    rx_hunt_filter #(.W(W), .NADDR(NADDR)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .addr_tab_i  (addr_tab),
        .chr_valid_i (chr_valid),
        .chr_data_i  (chr_data),
        .chr_addr_i  (chr_addr),
        .chr_ferr_i  (chr_ferr),
        .idle_i      (idle),
        .data_o      (data_o),
        .is_addr_o   (is_addr_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: rtl/mdrop_uart_rx_chk.sv
// Checker: port-level properties of the receiver, bound to the top.
// Assumes: len_i and mode_i are stable while a character is delivered.
module mdrop_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic [1:0] len_i,
    input logic [7:0] addr0_i,
    input logic [7:0] addr1_i,
    input logic [7:0] data_o,
    input logic       is_addr_o,
    input logic       valid_o,
    input logic       frame_err_o
);
    // R1: outputs are cleared on the cycle after reset is sampled.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !frame_err_o && !is_addr_o && data_o == 8'd0));

    // R2: bits at and above the character length are zero.
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((data_o >> (4'd5 + {2'b00, len_i})) == 8'd0));

    // R4: the address flag appears only in the multidrop modes.
    assert_flag_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && is_addr_o) |-> mode_i[0]);

    // R5: a flagged address in automatic mode equals a stored address.
    assert_auto_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && is_addr_o && mode_i == 2'b11) |-> (data_o == addr0_i || data_o == addr1_i));

    // R10: the strobes never coincide and each lasts one cycle.
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && frame_err_o));
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_ferr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);
endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .len_i       (len_i),
    .addr0_i     (addr0_i),
    .addr1_i     (addr1_i),
    .data_o      (data_o),
    .is_addr_o   (is_addr_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
);

// File: tb/tb_mdrop_uart_rx.sv
// Scoreboard bench: the driver sends frames and queues the expected
// characters; the monitor pops and compares them as they arrive.
module tb_mdrop_uart_rx;
    localparam int OVS = 16;
    localparam int DIV = 4;
    localparam int BIT = OVS * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic [1:0] len_i = 2'b11;
    logic [7:0] addr0_i = 8'h21;
    logic [7:0] addr1_i = 8'h42;
    logic [7:0] data_o;
    logic       is_addr_o;
    logic       valid_o;
    logic       frame_err_o;

    typedef struct {
        logic [7:0] d;
        logic       a;
        string      r;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   exp_ferr = 0;
    int   obs_ferr = 0;
    bit   model_hunt = 1'b1;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    mdrop_uart_rx #(.OVS(OVS), .DIV(DIV)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx_i),
        .mode_i      (mode_i),
        .len_i       (len_i),
        .addr0_i     (addr0_i),
        .addr1_i     (addr1_i),
        .data_o      (data_o),
        .is_addr_o   (is_addr_o),
        .valid_o     (valid_o),
        .frame_err_o (frame_err_o)
    );

    // Monitor: compare each delivered character with the queue head.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            n_run++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R3/R6 unexpected character data=%h flag=%b expected none", data_o, is_addr_o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (data_o !== e.d || is_addr_o !== e.a) begin
                    n_fail++;
                    $display("FAIL %s data=%h flag=%b expected data=%h flag=%b", e.r, data_o, is_addr_o, e.d, e.a);
                end
            end
        end
        if (rst_n && frame_err_o) obs_ferr++;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(input logic v, input int clocks);
        @(negedge clk);
        rx_i = v;
        repeat (clocks - 1) @(negedge clk);
    endtask

    function automatic int nbits();
        return 5 + int'(len_i);
    endfunction

    // Start a segment: reset, check cleared outputs (R1), model hunting.
    task automatic do_reset(input logic [1:0] m, input logic [1:0] l);
        rst_n = 1'b0;
        rx_i = 1'b1;
        mode_i = m;
        len_i = l;
        repeat (4) @(negedge clk);
        check(valid_o == 1'b0 && frame_err_o == 1'b0 && data_o == 8'd0 && is_addr_o == 1'b0,
              "R1 reset outputs", int'(data_o), 0);
        rst_n = 1'b1;
        model_hunt = 1'b1;
        exp_ferr = 0;
        obs_ferr = 0;
    endtask

    // Driver: update the reference model, queue the expectation, send the frame.
    task automatic send(input logic [7:0] d, input logic ab, input bit stop_ok,
                        input int gap_bits, input string req);
        logic [7:0] md;
        logic       abit;
        md = d & 8'((1 << nbits()) - 1);
        abit = mode_i[0] ? ab : 1'b0;
        if (!stop_ok) begin
            exp_ferr++;
            model_hunt = 1'b1;
        end else if (mode_i == 2'b01) begin
            if (abit) begin
                q.push_back('{md, 1'b1, req});
                model_hunt = 1'b0;
            end else if (!model_hunt) q.push_back('{md, 1'b0, req});
        end else if (mode_i == 2'b11) begin
            if (abit) begin
                if (md == addr0_i || md == addr1_i) begin
                    q.push_back('{md, 1'b1, req});
                    model_hunt = 1'b0;
                end else model_hunt = 1'b1;
            end else if (!model_hunt) q.push_back('{md, 1'b0, req});
        end else if (!model_hunt) begin
            q.push_back('{md, 1'b0, req});
        end
        drive(1'b0, BIT);
        for (int i = 0; i < nbits(); i++) drive(d[i], BIT);
        if (mode_i[0]) drive(ab, BIT);
        drive(stop_ok ? 1'b1 : 1'b0, BIT);
        if (gap_bits > 0) drive(1'b1, gap_bits * BIT);
    endtask

    // Hold the line idle; a long enough gap ends the hunt in normal mode (R3).
    task automatic idle_line(input int bits);
        drive(1'b1, bits * BIT);
        if (!mode_i[0] && bits >= nbits() + 3) model_hunt = 1'b0;
    endtask

    // End of segment: all expected characters seen, error count matches.
    task automatic settle(input string req);
        drive(1'b1, 3 * BIT);
        check(q.size() == 0, {req, " missing characters"}, q.size(), 0);
        check(obs_ferr == exp_ferr, "R7 framing error count", obs_ferr, exp_ferr);
        q.delete();
    endtask

    initial begin
        // Normal mode, 8 bits.
        do_reset(2'b00, 2'b11);
        send(8'h55, 1'b0, 1'b1, 2, "R3 dropped while hunting");
        idle_line(12);
        send(8'hA5, 1'b0, 1'b1, 0, "R8 back-to-back 1");
        send(8'h3C, 1'b0, 1'b1, 0, "R8 back-to-back 2");
        send(8'hFF, 1'b0, 1'b1, 0, "R3 all ones data");
        send(8'h00, 1'b0, 1'b1, 2, "R3 all zero data");
        len_i = 2'b00;
        send(8'h1F, 1'b0, 1'b1, 2, "R2 five bits");
        send(8'hF3, 1'b0, 1'b1, 2, "R2 five bits masked");
        len_i = 2'b10;
        send(8'h7E, 1'b0, 1'b1, 2, "R2 seven bits");
        len_i = 2'b01;
        send(8'h2A, 1'b0, 1'b1, 2, "R2 six bits");
        len_i = 2'b11;
        drive(1'b0, BIT / 4);
        drive(1'b1, 2 * BIT);
        check(q.size() == 0 && obs_ferr == 0, "R9 glitch ignored", obs_ferr, 0);
        send(8'h44, 1'b0, 1'b0, 2, "R7 bad stop");
        send(8'h22, 1'b0, 1'b1, 2, "R7 hunt after error");
        idle_line(12);
        send(8'h23, 1'b0, 1'b1, 2, "R3 after idle");
        settle("R3");

        // Reserved mode acts as normal.
        do_reset(2'b10, 2'b11);
        send(8'h66, 1'b0, 1'b1, 2, "R3 reserved hunting");
        idle_line(12);
        send(8'h67, 1'b0, 1'b1, 2, "R3 reserved accepted");
        settle("R3");

        // Manual multidrop.
        do_reset(2'b01, 2'b11);
        send(8'h10, 1'b0, 1'b1, 2, "R4 data while hunting");
        idle_line(14);
        send(8'h11, 1'b0, 1'b1, 2, "R6 idle no exit in multidrop");
        send(8'h05, 1'b1, 1'b1, 2, "R4 address flagged");
        send(8'h77, 1'b0, 1'b1, 0, "R4 data after address");
        send(8'h78, 1'b0, 1'b1, 2, "R4 data second");
        send(8'hE6, 1'b1, 1'b1, 2, "R4 another address");
        settle("R4");

        // Automatic multidrop.
        do_reset(2'b11, 2'b11);
        send(8'h01, 1'b0, 1'b1, 2, "R6 data while hunting");
        send(8'h30, 1'b1, 1'b1, 2, "R6 unmatched address");
        send(8'h21, 1'b1, 1'b1, 2, "R5 match first address");
        send(8'h99, 1'b0, 1'b1, 2, "R5 data after match");
        send(8'h55, 1'b1, 1'b1, 2, "R6 unmatched address re-hunt");
        send(8'h98, 1'b0, 1'b1, 2, "R6 data discarded");
        send(8'h42, 1'b1, 1'b1, 2, "R5 match second address");
        send(8'h97, 1'b0, 1'b1, 0, "R5 data after second");
        len_i = 2'b01;
        send(8'h21, 1'b1, 1'b1, 2, "R5 six-bit address");
        send(8'h3B, 1'b0, 1'b1, 2, "R5 six-bit data");
        send(8'h21, 1'b1, 1'b0, 2, "R7 error on address");
        send(8'h12, 1'b0, 1'b1, 2, "R7 data after error");
        idle_line(14);
        send(8'h13, 1'b0, 1'b1, 2, "R6 idle no exit");
        settle("R5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule